// File: doc/BRIEF.md
# Row/Column Multiplexed Address Front End

This block is the parallel programming-mode front end of a flash device. Eleven address pins are shared between two halves of a 19-bit array address. A row/column select strobe decides which half is captured. Its falling edge latches the low 11 address bits from all pins. Its rising edge latches the upper 8 bits from the lower 8 pins. An 8-bit data bus carries read data out under an active-low output enable, and carries program data in under an active-low write enable. A ready flag goes low while an array operation runs. An external done pulse releases it.

All pins are sampled into the system clock domain, and every output is registered. A mode input picks between this interface and the serial nibble bus that another block serves. While the mode input is low, this block ignores every strobe and leaves the data bus released. The bus is brought out as separate input, output and enable vectors, so that a pad-level tri-state buffer can be placed at the chip edge. The outputs towards the array are the latched address, a one-cycle read strobe, a one-cycle write strobe with its captured byte, and the ready flag.

Top module: `amux_front`

## Requirements
- R1: After reset, mem_addr is 0, ready is 1, rd_stb and wr_stb are 0, wr_data is 0 and data_oe is 0 (bus released).
- R2: In parallel mode (mode_sel=1), a falling edge on rc_sel copies addr_pins[10:0] into mem_addr[10:0]. The value is visible from the second clock edge after the pin change, and mem_addr[18:11] is left unchanged.
- R3: In parallel mode, a rising edge on rc_sel copies addr_pins[7:0] into mem_addr[18:11]. addr_pins[10:8] are ignored, mem_addr[10:0] is left unchanged, and the timing is the same as in R2.
- R4: While rc_sel holds its level, changes on addr_pins have no effect on mem_addr.
- R5: In parallel mode, with oe_n=0 and we_n=1, data_oe is 1 and data_out equals rd_data from the second clock edge onward. Two clock edges after oe_n returns high, data_oe is 0.
- R6: Each falling edge of oe_n in parallel mode gives exactly one rd_stb pulse, one cycle long, at the second clock edge.
- R7: In parallel mode with ready=1, a rising edge of we_n captures data_in into wr_data and gives a one-cycle wr_stb pulse at the second clock edge. ready goes to 0 at that same edge.
- R8: ready returns to 1 at the clock edge that samples op_done=1.
- R9: A rising edge of we_n while ready=0 gives no wr_stb and leaves wr_data unchanged.
- R10: With mode_sel=0, rc_sel, oe_n and we_n edges change neither mem_addr nor wr_data, give no strobe, and data_oe stays 0.
- R11: While we_n is low, data_oe stays 0 even if oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 1 selects this multiplexed interface, 0 the nibble bus |
| addr_pins | input | 11 | Shared row/column address pins |
| rc_sel | input | 1 | Row/column select: fall latches row, rise latches column |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; rising edge captures data |
| data_in | input | 8 | Data bus, pad input side |
| data_out | output | 8 | Data bus, pad output side |
| data_oe | output | 1 | Data bus pad drive enable |
| rd_data | input | 8 | Read byte from the array |
| op_done | input | 1 | Pulse that marks the end of an array operation |
| mem_addr | output | 19 | Latched array address |
| rd_stb | output | 1 | One-cycle read request to the array |
| wr_stb | output | 1 | One-cycle write request to the array |
| wr_data | output | 8 | Captured program byte |
| ready | output | 1 | 1 when idle, 0 while an operation runs |

## Verification
A corrupted half-address register shows up on mem_addr at the next latch event. It can also show up earlier: a pin change while rc_sel is steady would move the address at once, two clocks after the stimulus. A stuck busy flag is seen as a missing wr_stb on the following write. A lost edge register shows up as a missing or doubled strobe within two cycles of the pin edge. A wrong drive enable is caught on data_oe at the second edge after any oe_n, we_n or mode_sel change. Random sequences of latches, reads, writes, done pulses and mode switches are compared against a bench model after every operation.

// File: rtl/amux_pkg.sv
package amux_pkg;
  localparam int PIN_W_DEF  = 11;
  localparam int ADDR_W_DEF = 19;
  localparam int DATA_W_DEF = 8;

  typedef struct packed {
    logic rc;
    logic oe_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{rc: 1'b1, oe_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/amux_pin_sync.sv
module amux_pin_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl[i]  <= RST_VAL[i];
        prev[i] <= RST_VAL[i];
      end else begin
        lvl[i]  <= pin[i];
        prev[i] <= lvl[i];
      end
    end
    assign rise[i] = lvl[i] & ~prev[i];
    assign fall[i] = ~lvl[i] & prev[i];

    assert property (@(posedge clk) disable iff (rst) rise[i] |=> !rise[i])
      else $error("edge pulse repeated");
  end
endmodule

// File: rtl/amux_addr_latch.sv
module amux_addr_latch #(
  parameter int PIN_W  = 11,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              row_edge,
  input  logic              col_edge,
  input  logic [PIN_W-1:0]  pins,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int COL_W = ADDR_W - PIN_W;

  logic [PIN_W-1:0] pins_q;
  logic             take_row;
  logic             take_col;

  assign take_row = en & row_edge;
  assign take_col = en & col_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q   <= '0;
      mem_addr <= '0;
    end else begin
      pins_q <= pins;
      if (take_row) mem_addr[PIN_W-1:0]      <= pins_q;
      if (take_col) mem_addr[ADDR_W-1:PIN_W] <= pins_q[COL_W-1:0];
    end
  end

  assert_row_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr[PIN_W-1:0]) |-> $past(take_row))
    else $error("row half moved without a row edge");
  assert_col_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr[ADDR_W-1:PIN_W]) |-> $past(take_col))
    else $error("column half moved without a column edge");
  assert_mode_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(mem_addr))
    else $error("address moved in nibble-bus mode");
endmodule

// File: rtl/amux_data_port.sv
module amux_data_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              oe_lvl,
  input  logic              oe_fall,
  input  logic              we_lvl,
  input  logic              we_rise,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              op_done,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              ready
);
  logic [DATA_W-1:0] din_q;
  logic              wr_go;

  assign wr_go = en & we_rise & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q    <= '0;
      data_out <= '0;
      data_oe  <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
      ready    <= 1'b1;
    end else begin
      din_q   <= data_in;
      data_oe <= en & ~oe_lvl & we_lvl;
      rd_stb  <= en & oe_fall;
      wr_stb  <= wr_go;
      if (!oe_lvl) data_out <= rd_data;
      if (wr_go) wr_data <= din_q;
      if (op_done)    ready <= 1'b1;
      else if (wr_go) ready <= 1'b0;
    end
  end

  assert_busy_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !ready)
    else $error("write strobe without busy");
  assert_write_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(ready))
    else $error("write accepted while busy");
  assert_ready_by_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(op_done))
    else $error("ready rose without done");
  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb)
    else $error("read strobe longer than one cycle");
  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb)
    else $error("write strobe longer than one cycle");
  assert_no_drive_in_write_R11: assert property (@(posedge clk) disable iff (rst)
    (!we_lvl && !$past(we_lvl)) |-> !data_oe)
    else $error("bus driven during write");
endmodule

// File: rtl/amux_front.sv
module amux_front #(
  parameter int PIN_W  = amux_pkg::PIN_W_DEF,
  parameter int ADDR_W = amux_pkg::ADDR_W_DEF,
  parameter int DATA_W = amux_pkg::DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic              rc_sel,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              op_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              ready
);
  import amux_pkg::*;

  ctl_t ctl_pin, ctl_lvl, ctl_rise, ctl_fall;
  logic mode_q;

  assign ctl_pin = '{rc: rc_sel, oe_n: oe_n, we_n: we_n};

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= mode_sel;
  end

  amux_pin_sync #(.W($bits(ctl_t)), .RST_VAL(CTL_IDLE)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ctl_pin),
    .lvl  (ctl_lvl),
    .rise (ctl_rise),
    .fall (ctl_fall)
  );

  amux_addr_latch #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .en       (mode_q),
    .row_edge (ctl_fall.rc),
    .col_edge (ctl_rise.rc),
    .pins     (addr_pins),
    .mem_addr (mem_addr)
  );

  amux_data_port #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .en       (mode_q),
    .oe_lvl   (ctl_lvl.oe_n),
    .oe_fall  (ctl_fall.oe_n),
    .we_lvl   (ctl_lvl.we_n),
    .we_rise  (ctl_rise.we_n),
    .data_in  (data_in),
    .rd_data  (rd_data),
    .op_done  (op_done),
    .data_out (data_out),
    .data_oe  (data_oe),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .ready    (ready)
  );

  assert_hiz_other_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (!mode_sel && !$past(mode_sel)) |=> !data_oe && !rd_stb && !wr_stb)
    else $error("activity in nibble-bus mode");
endmodule

// File: tb/amux_front_tb_top.sv
module amux_front_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sel = 1'b1;
  logic [10:0] addr_pins = '0;
  logic        rc_sel = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  data_in = '0, rd_data = '0;
  logic        op_done = 1'b0;
  logic [7:0]  data_out, wr_data;
  logic        data_oe, rd_stb, wr_stb, ready;
  logic [18:0] mem_addr;

  int checks = 0, errors = 0;
  logic [18:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  logic        m_ready = 1'b1;

  always #2 clk = ~clk;

  amux_front dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr_pins(addr_pins),
    .rc_sel(rc_sel), .oe_n(oe_n), .we_n(we_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .rd_data(rd_data),
    .op_done(op_done), .mem_addr(mem_addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [18:0] row_model(logic [18:0] a, logic [10:0] p);
    return {a[18:11], p};
  endfunction
  function automatic logic [18:0] col_model(logic [18:0] a, logic [10:0] p);
    return {p[7:0], a[10:0]};
  endfunction

  task automatic do_row(input logic [10:0] p);
    addr_pins = p; rc_sel = 1'b0;
    if (mode_sel) m_addr = row_model(m_addr, p);
    step(2);
    chk(mem_addr == m_addr, mode_sel ? "R2 row latch" : "R10 row ignored", mem_addr, m_addr);
  endtask

  task automatic do_col(input logic [10:0] p);
    addr_pins = p; rc_sel = 1'b1;
    if (mode_sel) m_addr = col_model(m_addr, p);
    step(2);
    chk(mem_addr == m_addr, mode_sel ? "R3 column latch" : "R10 column ignored", mem_addr, m_addr);
  endtask

  task automatic do_noise(input logic [10:0] p);
    addr_pins = p;
    step(3);
    chk(mem_addr == m_addr, "R4 pins ignored without edge", mem_addr, m_addr);
  endtask

  task automatic do_write(input logic [7:0] d);
    bit acc;
    data_in = d; we_n = 1'b0;
    step(2);
    chk(data_oe == 1'b0, "R11 no drive during write", data_oe, 0);
    we_n = 1'b1;
    acc = mode_sel && m_ready;
    if (acc) begin m_wdata = d; m_ready = 1'b0; end
    step(2);
    chk(wr_stb == acc, acc ? "R7 write strobe" : (mode_sel ? "R9 busy write dropped" : "R10 write ignored"), wr_stb, acc);
    chk(wr_data == m_wdata, acc ? "R7 write data" : "R9 write data kept", wr_data, m_wdata);
    chk(ready == m_ready, "R7 ready after write", ready, m_ready);
    step(1);
    chk(wr_stb == 1'b0, "R7 write strobe one cycle", wr_stb, 0);
  endtask

  task automatic do_done();
    op_done = 1'b1;
    m_ready = 1'b1;
    step(1);
    op_done = 1'b0;
    chk(ready == 1'b1, "R8 ready after done", ready, 1);
  endtask

  task automatic do_read(input logic [7:0] v, input bit we_low);
    bit act;
    rd_data = v;
    if (we_low) begin we_n = 1'b0; step(2); end
    oe_n = 1'b0;
    act = mode_sel && !we_low;
    step(2);
    chk(rd_stb == mode_sel, mode_sel ? "R6 read strobe" : "R10 no read strobe", rd_stb, mode_sel);
    chk(data_oe == act, we_low ? "R11 write blocks drive" : (mode_sel ? "R5 bus driven" : "R10 bus released"), data_oe, act);
    if (act) chk(data_out == v, "R5 read data", data_out, v);
    step(1);
    chk(rd_stb == 1'b0, "R6 read strobe one cycle", rd_stb, 0);
    oe_n = 1'b1;
    step(2);
    chk(data_oe == 1'b0, "R5 bus released after oe", data_oe, 0);
    if (we_low) begin
      we_n = 1'b1;
      if (mode_sel && m_ready) begin m_wdata = data_in; m_ready = 1'b0; end
      step(3);
    end
  endtask

  task automatic set_mode(input bit m);
    mode_sel = m;
    step(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd12345));
    step(3);
    rst = 1'b0;
    step(1);
    chk(mem_addr == 0, "R1 reset address", mem_addr, 0);
    chk(ready == 1'b1, "R1 reset ready", ready, 1);
    chk({rd_stb, wr_stb, data_oe} == 3'b000, "R1 reset strobes and drive", {rd_stb, wr_stb, data_oe}, 0);
    chk(wr_data == 0, "R1 reset write data", wr_data, 0);

    // directed corners
    do_row(11'h7FF);
    do_col(11'h7FF);
    do_row(11'h000);
    do_col(11'h700);
    do_noise(11'h2A5);
    do_write(8'hA5);
    do_write(8'h3C);
    do_done();
    do_read(8'h96, 1'b0);
    do_read(8'h11, 1'b1);
    do_done();
    set_mode(1'b0);
    do_row(11'h155);
    do_col(11'h0AA);
    do_write(8'hEE);
    do_read(8'h77, 1'b0);
    set_mode(1'b1);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: begin do_row(11'($urandom)); do_col(11'($urandom)); end
        1: do_noise(11'($urandom));
        2: do_write(8'($urandom));
        3: do_done();
        4: do_read(8'($urandom), $urandom_range(0, 4) == 0);
        default: begin
          set_mode(1'b0);
          if ($urandom_range(0, 1) == 1) begin do_row(11'($urandom)); do_col(11'($urandom)); end
          else do_write(8'($urandom));
          set_mode(1'b1);
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule